// File: doc/BRIEF.md
# Multi-port transmit word demultiplexer

This block sits on the receiving side of a 32-bit packet transmit bus shared by four ports. On each clock it samples a word, an active-low enable, an address-cycle marker, start/end/error flags and a two-bit end-of-packet byte count. A cycle with the address marker high while the enable is deasserted picks the destination port. Later enabled words are steered to that port. They are emitted one cycle later with a byte-enable vector, the port index and the packet flags.

The block also answers status polling. A two-bit poll address picks one port's space-available input. That bit comes back, registered, on a single ready output. A sticky per-port flag records a packet that carried a nonzero byte count on a word that was not its last.

Top module: `txPortDemux`

## Requirements
- R1: After reset, outValid, pollReady and every bit of modViolation are 0, and the selected port is 0.
- R2: A cycle with txEnN high and txAddrSel high is an address cycle. It sets the selected port to txData[1:0], and every other txData bit has no effect on the choice.
- R3: While txEnN is low, txAddrSel has no effect, and the selected port keeps its value.
- R4: A word sampled with txEnN low appears one cycle later with outValid high. It carries outData equal to the sampled txData, outPort equal to the selected port, and outSop, outEop, outErr equal to the sampled flags.
- R5: On a word with txEop high, outBe (bit 3 = byte [31:24], bit 0 = byte [7:0]) follows txMod: 00 gives 1111, 01 gives 1110, 10 gives 1100, 11 gives 1000.
- R6: On a word with txEop low, outBe is 1111 whatever txMod holds. If txMod is nonzero there, bit N of modViolation is set for selected port N and stays set until reset.
- R7: A cycle with txEnN high and txAddrSel low produces outValid low with outSop, outEop and outErr low, and leaves the selected port unchanged.
- R8: pollReady equals spaceAvail[pollAddr] as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 32 | Data word, or the port number in bits [1:0] during an address cycle |
| txEnN | input | 1 | Active-low word enable |
| txAddrSel | input | 1 | Address-cycle marker, used only while txEnN is high |
| txSop | input | 1 | Start of packet |
| txEop | input | 1 | End of packet |
| txMod | input | 2 | Count of unused low bytes on the final word |
| txErr | input | 1 | Packet error marker |
| pollAddr | input | 2 | Port whose space status is polled |
| spaceAvail | input | 4 | Per-port space-available status |
| outValid | output | 1 | Output word valid |
| outData | output | 32 | Output word |
| outBe | output | 4 | Byte enables, most significant byte in bit 3 |
| outPort | output | 2 | Destination port of the output word |
| outSop | output | 1 | Start of packet, qualified by outValid |
| outEop | output | 1 | End of packet, qualified by outValid |
| outErr | output | 1 | Error marker, qualified by outValid |
| modViolation | output | 4 | Sticky per-port flag for a misplaced byte count |
| pollReady | output | 1 | Registered polled space status |

## Verification
The bench sends address cycles whose upper data bits are all ones, so a decoder that reads too many bits routes to the wrong port. It raises the address marker during enabled words; a design that honours it there switches ports in mid-packet. It sends every byte count on final words and nonzero counts on middle words: a swapped mask, or one applied to middle words, shows on outBe, and a flag that fails to latch or clears itself shows on modViolation. It also changes the poll address every cycle, so a combinational or doubly registered ready bit misses its cycle.

// File: rtl/txDemuxPkg.sv
package txDemuxPkg;
  // Strobes passed from the control side to the datapath
  typedef struct packed {
    logic takeWord;   // enabled word sampled this cycle
    logic lastWord;   // sampled word closes a packet
    logic modFault;   // nonzero byte count on a non-final word
  } ctrlStrobes_t;
endpackage

// File: rtl/txDemuxCtrl.sv
module txDemuxCtrl
  import txDemuxPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int MOD_W     = 2,
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enN,
  input  logic             addrMark,
  input  logic             eop,
  input  logic [MOD_W-1:0] mod,
  input  logic [SEL_W-1:0] addrBits,
  output ctrlStrobes_t     strobes,
  output logic [SEL_W-1:0] curPort
);
  logic addrCycle;

  // The address marker is honoured only while the enable is off
  assign addrCycle = enN && addrMark;

  always_comb begin
    strobes          = '0;
    strobes.takeWord = !enN;
    strobes.lastWord = !enN && eop;
    strobes.modFault = !enN && !eop && (mod != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPort <= '0;
    end else if (addrCycle) begin
      curPort <= addrBits;
    end
  end
endmodule

// File: rtl/txDemuxData.sv
module txDemuxData
  import txDemuxPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4,
  localparam int BYTES    = DATA_W / 8,
  localparam int MOD_W    = $clog2(BYTES),
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [SEL_W-1:0]     curPort,
  input  logic [DATA_W-1:0]    inData,
  input  logic [MOD_W-1:0]     inMod,
  input  logic                 inSop,
  input  logic                 inErr,
  input  logic [SEL_W-1:0]     pollAddr,
  input  logic [NUM_PORTS-1:0] spaceAvail,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic [BYTES-1:0]     outBe,
  output logic [SEL_W-1:0]     outPort,
  output logic                 outSop,
  output logic                 outEop,
  output logic                 outErr,
  output logic [NUM_PORTS-1:0] modViolation,
  output logic                 pollReady
);
  logic [BYTES-1:0]     beNext;
  logic [NUM_PORTS-1:0] faultHit;

  // Final word: the top (BYTES - mod) byte lanes are live
  always_comb begin
    beNext = '1;
    if (strobes.lastWord) begin
      for (int i = 0; i < BYTES; i++) begin
        beNext[i] = (i >= int'(inMod));
      end
    end
  end

  // One flag per port; a fault touches only the selected port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fault
    assign faultHit[p] = strobes.modFault && (curPort == SEL_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid     <= 1'b0;
      outData      <= '0;
      outBe        <= '0;
      outPort      <= '0;
      outSop       <= 1'b0;
      outEop       <= 1'b0;
      outErr       <= 1'b0;
      modViolation <= '0;
      pollReady    <= 1'b0;
    end else begin
      outValid     <= strobes.takeWord;
      outSop       <= strobes.takeWord && inSop;
      outEop       <= strobes.lastWord;
      outErr       <= strobes.takeWord && inErr;
      modViolation <= modViolation | faultHit;
      pollReady    <= spaceAvail[pollAddr];
      if (strobes.takeWord) begin
        outData <= inData;
        outBe   <= beNext;
        outPort <= curPort;
      end
    end
  end
endmodule

// File: rtl/txPortDemux.sv
module txPortDemux
  import txDemuxPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4,
  localparam int BYTES    = DATA_W / 8,
  localparam int MOD_W    = $clog2(BYTES),
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    txData,
  input  logic                 txEnN,
  input  logic                 txAddrSel,
  input  logic                 txSop,
  input  logic                 txEop,
  input  logic [MOD_W-1:0]     txMod,
  input  logic                 txErr,
  input  logic [SEL_W-1:0]     pollAddr,
  input  logic [NUM_PORTS-1:0] spaceAvail,
  output logic                 outValid,
  output logic [DATA_W-1:0]    outData,
  output logic [BYTES-1:0]     outBe,
  output logic [SEL_W-1:0]     outPort,
  output logic                 outSop,
  output logic                 outEop,
  output logic                 outErr,
  output logic [NUM_PORTS-1:0] modViolation,
  output logic                 pollReady
);
  ctrlStrobes_t     strobes;
  logic [SEL_W-1:0] curPort;

  txDemuxCtrl #(.NUM_PORTS(NUM_PORTS), .MOD_W(MOD_W)) ctrl (
    .clk(clk), .rstN(rstN), .enN(txEnN), .addrMark(txAddrSel),
    .eop(txEop), .mod(txMod), .addrBits(txData[SEL_W-1:0]),
    .strobes(strobes), .curPort(curPort)
  );

  txDemuxData #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPort(curPort),
    .inData(txData), .inMod(txMod), .inSop(txSop), .inErr(txErr),
    .pollAddr(pollAddr), .spaceAvail(spaceAvail),
    .outValid(outValid), .outData(outData), .outBe(outBe),
    .outPort(outPort), .outSop(outSop), .outEop(outEop),
    .outErr(outErr), .modViolation(modViolation), .pollReady(pollReady)
  );
endmodule

// File: rtl/txDemuxChecker.sv
module txDemuxChecker #(
  parameter int DATA_W    = 32,
  parameter int NUM_PORTS = 4,
  localparam int BYTES    = DATA_W / 8,
  localparam int MOD_W    = $clog2(BYTES),
  localparam int SEL_W    = $clog2(NUM_PORTS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_W-1:0]    txData,
  input logic                 txEnN,
  input logic                 txEop,
  input logic [SEL_W-1:0]     pollAddr,
  input logic [NUM_PORTS-1:0] spaceAvail,
  input logic                 outValid,
  input logic [DATA_W-1:0]    outData,
  input logic [BYTES-1:0]     outBe,
  input logic                 outEop,
  input logic                 outSop,
  input logic                 outErr,
  input logic [NUM_PORTS-1:0] modViolation,
  input logic                 pollReady
);
  p_word_out_r4: assert property (@(posedge clk) disable iff (!rstN)
    !txEnN |=> (outValid && outData == $past(txData) && outEop == $past(txEop)));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEnN |=> (!outValid && !outSop && !outEop && !outErr));

  p_full_middle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outEop) |-> (outBe == '1));

  p_top_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outBe[BYTES-1]);

  p_sticky_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(modViolation) & ~modViolation) == '0));

  p_poll_delay_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pollReady == $past(spaceAvail[pollAddr])));
endmodule

bind txPortDemux txDemuxChecker #(.DATA_W(DATA_W), .NUM_PORTS(NUM_PORTS)) chk (
  .clk(clk), .rstN(rstN), .txData(txData), .txEnN(txEnN), .txEop(txEop),
  .pollAddr(pollAddr), .spaceAvail(spaceAvail), .outValid(outValid),
  .outData(outData), .outBe(outBe), .outEop(outEop), .outSop(outSop),
  .outErr(outErr), .modViolation(modViolation), .pollReady(pollReady)
);

// File: tb/txPortDemux_test.sv
module txPortDemux_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] txData = '0;
  logic        txEnN = 1'b1, txAddrSel = 1'b0, txSop = 1'b0, txEop = 1'b0, txErr = 1'b0;
  logic [1:0]  txMod = '0, pollAddr = '0;
  logic [3:0]  spaceAvail = '0;
  logic        outValid, outSop, outEop, outErr, pollReady;
  logic [31:0] outData;
  logic [3:0]  outBe, modViolation;
  logic [1:0]  outPort;

  int errors = 0, checks = 0;
  bit done = 0;

  txPortDemux uut (.*);

  always #2 clk = ~clk;

  // Behavioural reference model
  bit         eValid, eSop, eEop, eErr, ePoll;
  bit  [31:0] eData;
  bit  [3:0]  eBe, eViol;
  bit  [1:0]  ePort, mSel;

  always @(posedge clk) begin
    if (!rstN) begin
      eValid = 0; eSop = 0; eEop = 0; eErr = 0; ePoll = 0; eViol = 0; mSel = 0;
    end else begin
      eValid = !txEnN;
      eSop = !txEnN && txSop;
      eEop = !txEnN && txEop;
      eErr = !txEnN && txErr;
      if (!txEnN) begin
        eData = txData;
        ePort = mSel;
        if (txEop) begin
          case (txMod)
            2'd0: eBe = 4'b1111;
            2'd1: eBe = 4'b1110;
            2'd2: eBe = 4'b1100;
            default: eBe = 4'b1000;
          endcase
        end else begin
          eBe = 4'b1111;
          if (txMod != 0) eViol[mSel] = 1;
        end
      end else if (txAddrSel) begin
        mSel = txData[1:0];
      end
      ePoll = spaceAvail[pollAddr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(outValid == eValid, "R4/R7 valid", 32'(outValid), 32'(eValid));
      chk({outSop, outEop, outErr} == {eSop, eEop, eErr}, "R4 flags", 32'({outSop, outEop, outErr}), 32'({eSop, eEop, eErr}));
      if (eValid) begin
        chk(outData == eData, "R4 data", outData, eData);
        chk(outPort == ePort, "R2/R3 port", 32'(outPort), 32'(ePort));
        chk(outBe == eBe, "R5/R6 byte enables", 32'(outBe), 32'(eBe));
      end
      chk(modViolation == eViol, "R6 sticky flag", 32'(modViolation), 32'(eViol));
      chk(pollReady == ePoll, "R8 poll", 32'(pollReady), 32'(ePoll));
    end
  end

  task automatic step(input bit enN, input bit sel, input bit sop, input bit eop,
                      input bit [1:0] mod, input bit err, input bit [31:0] d);
    @(negedge clk);
    txEnN = enN; txAddrSel = sel; txSop = sop; txEop = eop; txMod = mod; txErr = err; txData = d;
    pollAddr = pollAddr + 2'd1;
    spaceAvail = {spaceAvail[2:0], ~spaceAvail[3] ^ spaceAvail[1]};
  endtask

  task automatic idle();
    step(1, 0, 0, 0, 0, 0, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, and first word goes to port 0
    chk(outValid == 0, "R1 valid", 32'(outValid), 0);
    chk(pollReady == 0 || pollReady == ePoll, "R1 poll", 32'(pollReady), 32'(ePoll));
    chk(modViolation == 0, "R1 flags", 32'(modViolation), 0);
    step(0, 0, 1, 1, 0, 0, 32'h1111_2222);
    idle();
    // R2: address with junk upper bits selects port 2
    step(1, 1, 0, 0, 0, 0, 32'hFFFF_FFFE);
    // R5: every byte count on final words; R3: marker ignored while enabled
    for (int m = 0; m < 4; m++) begin
      step(0, 1, 1, 0, 0, 0, 32'hA000_0000 + m);
      step(0, 1, 0, 0, 0, 0, 32'h0000_0003);
      step(0, 0, 0, 1, 2'(m), m == 2, 32'hC0DE_0000 + m);
      idle();
    end
    // R6: nonzero count on a middle word flags port 1
    step(1, 1, 0, 0, 0, 0, 32'h8000_0001);
    step(0, 0, 1, 0, 2'd2, 0, 32'h5555_AAAA);
    step(0, 0, 0, 1, 2'd1, 0, 32'h1234_5678);
    // R7: idle cycles keep port 1
    repeat (3) idle();
    step(0, 0, 1, 1, 2'd3, 1, 32'h0BAD_F00D);
    idle();
    // Random traffic
    for (int i = 0; i < 600; i++) begin
      bit [31:0] r = $urandom;
      step(r[0], r[1], r[2], r[3], r[5:4], r[6], $urandom);
    end
    repeat (3) idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule